// File: doc/BRIEF.md
# Vector condition-result bit packer

This unit runs a masked test over a sequence of 4-bit condition fields and packs the one-bit outcomes into integer registers. A single start pulse latches the operation: the vector length, the first field index, whether the field source advances or stays fixed, whether the destination is one register or a run of registers, a 2-bit packing code, the test mask, the test mode and the combine selector. The unit then evaluates one element per clock through a combinational field read port, builds a packed word internally and sends each completed word out on a register write port.

Each element's outcome comes from comparing the field with the mode under the mask. Outcomes are combined with OR or AND, then placed at a slot in a word. With a vector destination, the packing code sets how many outcomes share one register (1, 2, 4 or 8), and the unused upper bits are zero. With a scalar destination, all outcomes are collected bit by bit into one register.

The register write port is a valid/ready stream. Once `wr_valid` is high, it stays high with `wr_idx` and `wr_data` unchanged until the cycle in which `wr_ready` is also high. That cycle is the transfer. While the port is stalled the unit does not evaluate further elements. After the final transfer the unit raises `done` for exactly one cycle.

Top module: `condvec_packer`

## Requirements
- R1: After reset, `wr_valid` and `done` are low and stay low until a start is accepted.
- R2: Term k (k = 0..3) is `test_mask[k] & (test_mode[k] == field[k])`, where field bit k is bit k of `fld_rd_data`. An element's outcome is the OR of the four terms when `any_mode`=1 and their AND when `any_mode`=0.
- R3: With `fld_is_vec`=1, element i reads field `base_fld + i` (modulo 2^FIELD_W). With `fld_is_vec`=0, every element reads field `base_fld`.
- R4: With `dst_is_vec`=1 and `pack_code`=00, element i is written to register `dst_reg + i` (modulo 2^REG_W), with the outcome in bit 0 and all other bits zero.
- R5: With `dst_is_vec`=1 and `pack_code` 01, 10 or 11, N = 2, 4 or 8 outcomes share one register. Element i goes to register `dst_reg + i/N` at bit `i mod N`, and bits N and above are zero.
- R6: With `dst_is_vec`=0, exactly one write goes to `dst_reg`. Element i is at bit i, and bits VL and above are zero.
- R7: A final word that is only partly filled is still written, with zeros in its unfilled slots.
- R8: When VL=0, the unit raises `done` with no write. A VL above 64 is treated as 64.
- R9: Writes leave in ascending register order. While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_idx` and `wr_data` stay unchanged.
- R10: `done` is a one-cycle pulse that follows the final transfer. A start that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; the operation fields are latched on this pulse |
| vl | input | 7 | Vector length, 0..64; larger values are clamped to 64 |
| base_fld | input | 7 | Index of the first condition field |
| fld_is_vec | input | 1 | 1: field index advances each element; 0: fixed field |
| dst_is_vec | input | 1 | 1: packed register run; 0: single register |
| pack_code | input | 2 | Outcomes per register: 00=1, 01=2, 10=4, 11=8 |
| dst_reg | input | 5 | First destination register index |
| test_mask | input | 4 | Per-bit enable of the test |
| test_mode | input | 4 | Per-bit expected field value |
| any_mode | input | 1 | 1: OR of the terms; 0: AND of the terms |
| fld_rd_idx | output | 7 | Condition field read index |
| fld_rd_data | input | 4 | Condition field read data (combinational) |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Register write ready |
| wr_idx | output | 5 | Register write index |
| wr_data | output | 64 | Register write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
A slot position off by one, or a word counter that advances at the wrong time, shows up on the first write of an operation as misplaced bits or a wrong `wr_idx`. A bench that compares every valid cycle against a model catches it on that cycle. An accumulator that is not cleared between words shows up on the second write as bits left over from the first word. A count or last-element error shows up as too many or too few writes, or as `done` arriving before the expected write queue is empty. Random stalls on `wr_ready` expose any state change made while a write is held.

// File: rtl/condvec_pkg.sv
package condvec_pkg;
  localparam int FLD_BITS = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } cv_state_e;

  typedef struct packed {
    logic                fld_vec;
    logic                dst_vec;
    logic [1:0]          code;
    logic [FLD_BITS-1:0] mask;
    logic [FLD_BITS-1:0] mode;
    logic                any;
  } cv_cfg_t;
endpackage

// File: rtl/condvec_eval.sv
module condvec_eval
  import condvec_pkg::*;
(
  input  logic [FLD_BITS-1:0] field,
  input  logic [FLD_BITS-1:0] mask,
  input  logic [FLD_BITS-1:0] mode,
  input  logic                any,
  output logic                outcome
);
  logic [FLD_BITS-1:0] term;

  for (genvar k = 0; k < FLD_BITS; k++) begin : g_term
    assign term[k] = mask[k] & ~(mode[k] ^ field[k]);
  end

  assign outcome = any ? (|term) : (&term);
endmodule

// File: rtl/condvec_slot.sv
module condvec_slot #(
  parameter int CNT_W = 7,
  parameter int POS_W = 6
) (
  input  logic [CNT_W-1:0] elem,
  input  logic             dst_vec,
  input  logic [1:0]       code,
  output logic [POS_W-1:0] pos,
  output logic             word_full,
  output logic [POS_W-1:0] lim
);
  always_comb begin
    unique case (code)
      2'd0:    lim = POS_W'(0);
      2'd1:    lim = POS_W'(1);
      2'd2:    lim = POS_W'(3);
      default: lim = POS_W'(7);
    endcase
  end

  always_comb begin
    if (dst_vec) begin
      pos       = elem[POS_W-1:0] & lim;
      word_full = ((elem[POS_W-1:0] & lim) == lim);
    end else begin
      pos       = elem[POS_W-1:0];
      word_full = 1'b0;
    end
  end
endmodule

// File: rtl/condvec_accum.sv
module condvec_accum #(
  parameter int DATA_W = 64,
  parameter int POS_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              set_en,
  input  logic [POS_W-1:0]  pos,
  input  logic              bit_in,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      word <= '0;
    end else if (set_en) begin
      word <= word | (DATA_W'(bit_in) << pos);
    end
  end

  // R7 a slot is only ever written once per word, so it is empty before it is set
  // slot_fresh_chk
  slot_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr) |-> (word[pos] == 1'b0));
endmodule

// File: rtl/condvec_packer.sv
module condvec_packer
  import condvec_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int VL_MAX  = 64,
  parameter int FIELD_W = 7,
  parameter int REG_W   = 5,
  localparam int CNT_W  = $clog2(VL_MAX + 1),
  localparam int POS_W  = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CNT_W-1:0]   vl,
  input  logic [FIELD_W-1:0] base_fld,
  input  logic               fld_is_vec,
  input  logic               dst_is_vec,
  input  logic [1:0]         pack_code,
  input  logic [REG_W-1:0]   dst_reg,
  input  logic [3:0]         test_mask,
  input  logic [3:0]         test_mode,
  input  logic               any_mode,
  output logic [FIELD_W-1:0] fld_rd_idx,
  input  logic [3:0]         fld_rd_data,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [REG_W-1:0]   wr_idx,
  output logic [DATA_W-1:0]  wr_data,
  output logic               done
);
  cv_state_e          state;
  cv_cfg_t            cfg;
  logic [CNT_W-1:0]   vl_q;
  logic [CNT_W-1:0]   elem;
  logic [FIELD_W-1:0] base_q;
  logic [REG_W-1:0]   widx_q;
  logic               last_q;

  logic               outcome;
  logic [POS_W-1:0]   pos;
  logic [POS_W-1:0]   lim;
  logic               word_full;
  logic               is_last;
  logic               run_step;
  logic               xfer;
  logic               acc_clr;
  logic [CNT_W-1:0]   vl_clamped;

  assign vl_clamped = (vl > CNT_W'(VL_MAX)) ? CNT_W'(VL_MAX) : vl;

  assign fld_rd_idx = cfg.fld_vec ? (base_q + FIELD_W'(elem)) : base_q;

  condvec_eval u_eval (
    .field   (fld_rd_data),
    .mask    (cfg.mask),
    .mode    (cfg.mode),
    .any     (cfg.any),
    .outcome (outcome)
  );

  condvec_slot #(.CNT_W(CNT_W), .POS_W(POS_W)) u_slot (
    .elem      (elem),
    .dst_vec   (cfg.dst_vec),
    .code      (cfg.code),
    .pos       (pos),
    .word_full (word_full),
    .lim       (lim)
  );

  assign run_step = (state == ST_RUN);
  assign is_last  = (elem == vl_q - CNT_W'(1));
  assign wr_valid = (state == ST_WRITE);
  assign xfer     = wr_valid && wr_ready;
  assign done     = (state == ST_DONE);
  assign wr_idx   = widx_q;
  assign acc_clr  = xfer || (state == ST_IDLE);

  condvec_accum #(.DATA_W(DATA_W), .POS_W(POS_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (acc_clr),
    .set_en (run_step),
    .pos    (pos),
    .bit_in (outcome),
    .word   (wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cfg    <= '0;
      vl_q   <= '0;
      elem   <= '0;
      base_q <= '0;
      widx_q <= '0;
      last_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            cfg.fld_vec <= fld_is_vec;
            cfg.dst_vec <= dst_is_vec;
            cfg.code    <= pack_code;
            cfg.mask    <= test_mask;
            cfg.mode    <= test_mode;
            cfg.any     <= any_mode;
            vl_q        <= vl_clamped;
            base_q      <= base_fld;
            widx_q      <= dst_reg;
            elem        <= '0;
            last_q      <= 1'b0;
            state       <= (vl_clamped == '0) ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          elem <= elem + CNT_W'(1);
          if (is_last || word_full) begin
            last_q <= is_last;
            state  <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (wr_ready) begin
            widx_q <= widx_q + REG_W'(1);
            state  <= last_q ? ST_DONE : ST_RUN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9 a held write keeps its contents
  // hold_stable_chk
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_idx)));

  // R10 done lasts a single cycle
  // done_pulse_chk
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10 done only follows a transfer or an empty run
  // done_after_xfer_chk
  done_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(xfer) || ($past(state) == ST_IDLE)));

  // R5 bits above the packing width are zero on a vector destination
  // upper_zero_chk
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && cfg.dst_vec) |-> ((wr_data >> (lim + POS_W'(1))) == '0));

  // R8 the element counter never passes the latched length
  // elem_bound_chk
  elem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (elem <= vl_q && vl_q <= CNT_W'(VL_MAX)));
endmodule

// File: tb/condvec_packer_tb.sv
module condvec_packer_tb;
  localparam int DATA_W = 64;
  localparam int FIELD_W = 7;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [6:0] vl = '0;
  logic [FIELD_W-1:0] base_fld = '0;
  logic fld_is_vec = 1'b0, dst_is_vec = 1'b0, any_mode = 1'b0;
  logic [1:0] pack_code = '0;
  logic [REG_W-1:0] dst_reg = '0;
  logic [3:0] test_mask = '0, test_mode = '0;
  logic [FIELD_W-1:0] fld_rd_idx;
  logic [3:0] fld_rd_data;
  logic wr_valid, done;
  logic wr_ready = 1'b1;
  logic [REG_W-1:0] wr_idx;
  logic [DATA_W-1:0] wr_data;

  logic [3:0] crf [128];
  assign fld_rd_data = crf[fld_rd_idx];

  always #2 clk = ~clk;

  condvec_packer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .base_fld(base_fld),
    .fld_is_vec(fld_is_vec), .dst_is_vec(dst_is_vec), .pack_code(pack_code),
    .dst_reg(dst_reg), .test_mask(test_mask), .test_mode(test_mode),
    .any_mode(any_mode), .fld_rd_idx(fld_rd_idx), .fld_rd_data(fld_rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx),
    .wr_data(wr_data), .done(done)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int rcnt = 0;
  bit stall = 0;
  bit in_op = 0;
  bit mon_on = 0;
  string cur_req = "R1";
  logic [REG_W-1:0]  q_idx[$];
  logic [DATA_W-1:0] q_dat[$];

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  // cycle-by-cycle compare against the queued model, then drive ready
  always @(negedge clk) begin
    bit nr;
    if (mon_on) begin
      if (wr_valid) begin
        n_chk++;
        if (q_idx.size() == 0) begin
          n_bad++;
          $display("FAIL %s: unexpected write idx=%0d data=%h expected none", cur_req, wr_idx, wr_data);
        end else if (wr_idx !== q_idx[0] || wr_data !== q_dat[0]) begin
          n_bad++;
          $display("FAIL %s: actual idx=%0d data=%h expected idx=%0d data=%h",
                   cur_req, wr_idx, wr_data, q_idx[0], q_dat[0]);
        end
      end
      if (done) begin
        n_chk++;
        if (!in_op || q_idx.size() != 0) begin
          n_bad++;
          $display("FAIL R10: done with %0d writes pending (in_op=%0d) expected 0 pending", q_idx.size(), in_op);
        end
        in_op = 0;
      end
    end
    rcnt++;
    nr = stall ? ((rcnt % 3) != 1) : 1'b1;
    if (wr_valid && nr && q_idx.size() != 0) begin
      void'(q_idx.pop_front());
      void'(q_dat.pop_front());
    end
    wr_ready <= nr;
  end

  function automatic logic eval_ref(input logic [3:0] f, input logic [3:0] mk,
                                    input logic [3:0] md, input logic any);
    int hits = 0, need = 0;
    for (int k = 0; k < 4; k++) begin
      if (mk[k] && (md[k] == f[k])) hits++;
    end
    need = hits;
    if (any) return need > 0;
    return need == 4;
  endfunction

  task automatic run_op(input string req, input int len, input int base, input bit fv,
                        input bit dv, input int code, input int rt, input logic [3:0] mk,
                        input logic [3:0] md, input bit any, input bit poke_start);
    int eff, cap, nw, t;
    logic [DATA_W-1:0] words[64];
    logic r;
    eff = (len > 64) ? 64 : len;
    cap = dv ? (1 << code) : 64;
    nw = (eff + cap - 1) / cap;
    for (int w = 0; w < 64; w++) words[w] = '0;
    for (int i = 0; i < eff; i++) begin
      r = eval_ref(crf[fv ? ((base + i) % 128) : base], mk, md, any);
      words[i / cap][i % cap] = r;
    end
    for (int w = 0; w < nw; w++) begin
      q_idx.push_back(REG_W'((rt + w) % 32));
      q_dat.push_back(words[w]);
    end
    cur_req = req;
    @(negedge clk);
    vl = 7'(len); base_fld = FIELD_W'(base); fld_is_vec = fv; dst_is_vec = dv;
    pack_code = 2'(code); dst_reg = REG_W'(rt); test_mask = mk; test_mode = md;
    any_mode = any; start = 1'b1; in_op = 1;
    @(negedge clk);
    start = 1'b0;
    vl = 7'd1; dst_reg = 5'd9; test_mask = ~mk; pack_code = ~2'(code);
    if (poke_start) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (in_op && t < 2000) begin
      @(negedge clk); t++;
    end
    n_chk++;
    if (in_op) begin
      n_bad++;
      $display("FAIL %s: actual no done expected done", req);
      in_op = 0;
    end
    q_idx.delete(); q_dat.delete();
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) crf[i] = 4'((i * 7 + 3) ^ (i >> 2));
    repeat (3) @(negedge clk);
    n_chk++;
    if (wr_valid !== 1'b0 || done !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: actual valid=%b done=%b expected 0 0", wr_valid, done);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    n_chk++;
    if (wr_valid !== 1'b0 || done !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: idle actual valid=%b done=%b expected 0 0", wr_valid, done);
    end
    mon_on = 1;
    // R4 one outcome per register, R2 OR combine
    run_op("R4", 5, 2, 1, 1, 0, 3, 4'b0110, 4'b0101, 1'b1, 0);
    // R5 two per register, partial last word (R7), R2 AND combine
    run_op("R7", 7, 10, 1, 1, 1, 0, 4'b1111, 4'b1011, 1'b0, 0);
    stall = 1;
    // R5 four per register under stalls (R9)
    run_op("R9", 10, 20, 1, 1, 2, 6, 4'b1001, 4'b0001, 1'b1, 0);
    // R3 fixed field source, R5 eight per register
    run_op("R3", 20, 44, 0, 1, 3, 12, 4'b0011, 4'b0011, 1'b0, 0);
    // R6 scalar destination, full length
    run_op("R6", 64, 0, 1, 0, 0, 17, 4'b1100, 4'b0100, 1'b1, 0);
    // R6 scalar destination, bits above VL zero
    run_op("R6", 13, 70, 1, 0, 2, 4, 4'b0101, 4'b0000, 1'b1, 0);
    stall = 0;
    // R8 empty length
    run_op("R8", 0, 5, 1, 1, 0, 2, 4'b1111, 4'b0000, 1'b1, 0);
    // R8 clamp to 64 outcomes
    run_op("R8", 100, 9, 1, 1, 1, 1, 4'b1010, 4'b1000, 1'b1, 0);
    // R3 wrap of field and register indices
    run_op("R3", 12, 122, 1, 1, 0, 28, 4'b0001, 4'b0001, 1'b1, 0);
    stall = 1;
    // R10 start during operation ignored
    run_op("R10", 24, 33, 1, 1, 2, 8, 4'b1110, 4'b0110, 1'b1, 1);
    // R2 zero mask with AND yields all zero
    run_op("R2", 9, 50, 1, 1, 3, 19, 4'b0000, 4'b0000, 1'b0, 0);
    finish_run();
  end
endmodule